// File: doc/BRIEF.md
# Packed String Compare Result Stage

This block is the last stage of a packed string compare unit. It receives the 16-bit aggregated match vector from the aggregation logic, the lengths of the two string operands and the 8-bit control byte of the operation. From these it forms either a 128-bit mask result or a 5-bit index result, as chosen by a mode input. It also forms the status flags of the operation.

One control bit selects the element width: 16 byte elements or 8 word elements. A second control bit changes the meaning of each result form. For the mask result it chooses between expanding each vector bit to a full element and zero-extending the raw vector. For the index result it chooses between searching from the top and searching from the bottom of the vector. A not-found index equals the element count.

An output register stage is present by default and is gated by a valid strobe. With the parameter `PIPE_EN` set to 0, the block is purely combinational.

Top module: `strcmp_result_stage`

## Requirements
- R1: `ctrl[0]`=1 selects word mode, with an element count of 8. `ctrl[0]`=0 selects byte mode, with an element count of 16.
- R2: In mask mode (`sel_index`=0) with `ctrl[6]`=1, element i of `mask_out` is all ones when vector bit i is set and zero otherwise. An element is `mask_out[16i+15:16i]` in word mode and `mask_out[8i+7:8i]` in byte mode.
- R3: In mask mode with `ctrl[6]`=0, `mask_out[15:0]` holds the effective vector and `mask_out[127:16]` is zero.
- R4: In index mode (`sel_index`=1) with `ctrl[6]`=1, `index_out` is the position of the highest set bit of the effective vector.
- R5: In index mode with `ctrl[6]`=0, `index_out` is the position of the lowest set bit of the effective vector.
- R6: In index mode, when no bit of the effective vector is set, `index_out` equals the element count (16 or 8).
- R7: `flags_out[0]` (carry) is 1 exactly when the effective vector is nonzero.
- R8: `flags_out[4]` (sign) is 1 when `len_a` is below the element count. `flags_out[3]` (zero) is 1 when `len_b` is below the element count. Any length at or above the count counts as full.
- R9: `flags_out[5]` (overflow) equals bit 0 of the effective vector. `flags_out[1]` (parity) and `flags_out[2]` (aux) are always 0.
- R10: In word mode, vector bits 15..8 are ignored by every output. The effective vector is the input with those bits cleared.
- R11: The output of the unselected form is zero: `mask_out` in index mode, `index_out` in mask mode.
- R12: With `PIPE_EN`=1, results appear one cycle after an `in_valid` cycle, with `out_valid`=1. Outputs hold while `in_valid` is 0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; enables the output register |
| match_vec | input | 16 | Aggregated match vector |
| len_a | input | 5 | First operand length, 0..16 |
| len_b | input | 5 | Second operand length, 0..16 |
| ctrl | input | 8 | Control byte (bit 0 width, bit 6 variant) |
| sel_index | input | 1 | 1 selects the index result, 0 the mask result |
| out_valid | output | 1 | Result valid |
| mask_out | output | 128 | Mask result |
| index_out | output | 5 | Index result |
| flags_out | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
The embedded assertions check, on every cycle, the relations between the separately built pieces:
- A not-found index coincides with a clear carry and equals the element count.
- The index never exceeds 16.
- Overflow implies carry.
- The unselected output stays zero.
- A valid input is followed by a valid output.

Only the bench's scenarios can show that the actual bit positions, the expanded lane contents, the search direction and the length comparisons are right. For this, the bench sweeps both widths, both modes and both variants across single-bit, all-zero, all-ones and pseudo-random vectors and across the full length range.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;
  localparam int VEC_W   = 16;
  localparam int LEN_W   = 5;
  localparam int OUT_W   = 128;
  localparam int IDX_W   = 5;
  localparam int BYTE_W  = OUT_W / VEC_W;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int WORD_N  = VEC_W / 2;
  localparam int FLAG_W  = 6;

  localparam int F_CARRY  = 0;
  localparam int F_PARITY = 1;
  localparam int F_AUX    = 2;
  localparam int F_ZERO   = 3;
  localparam int F_SIGN   = 4;
  localparam int F_OVF    = 5;

  localparam int C_WIDTH   = 0;
  localparam int C_VARIANT = 6;
endpackage

// File: rtl/strcmp_mask_expand.sv
module strcmp_mask_expand
  import strcmp_pkg::*;
(
  input  logic [VEC_W-1:0] eff_vec,
  input  logic             word_mode,
  input  logic             expand,
  output logic [OUT_W-1:0] mask
);
  logic [OUT_W-1:0] byte_mask;
  logic [OUT_W-1:0] word_mask;

  for (genvar g = 0; g < VEC_W; g++) begin : g_byte
    assign byte_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{eff_vec[g]}};
  end
  for (genvar g = 0; g < WORD_N; g++) begin : g_word
    assign word_mask[g*WORD_W +: WORD_W] = {WORD_W{eff_vec[g]}};
  end

  always_comb begin
    if (!expand)        mask = {{(OUT_W-VEC_W){1'b0}}, eff_vec};
    else if (word_mode) mask = word_mask;
    else                mask = byte_mask;
  end
endmodule

// File: rtl/strcmp_index_find.sv
module strcmp_index_find
  import strcmp_pkg::*;
(
  input  logic [VEC_W-1:0] eff_vec,
  input  logic [IDX_W-1:0] elem_cnt,
  input  logic             from_top,
  output logic [IDX_W-1:0] index
);
  always_comb begin
    index = elem_cnt;
    if (from_top) begin
      for (int i = 0; i < VEC_W; i++)
        if (eff_vec[i]) index = IDX_W'(i);
    end else begin
      for (int i = VEC_W-1; i >= 0; i--)
        if (eff_vec[i]) index = IDX_W'(i);
    end
  end
endmodule

// File: rtl/strcmp_flag_gen.sv
module strcmp_flag_gen
  import strcmp_pkg::*;
(
  input  logic [VEC_W-1:0]  eff_vec,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  input  logic [IDX_W-1:0]  elem_cnt,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags           = '0;
    flags[F_CARRY]  = |eff_vec;
    flags[F_SIGN]   = (len_a < elem_cnt);
    flags[F_ZERO]   = (len_b < elem_cnt);
    flags[F_OVF]    = eff_vec[0];
  end
endmodule

// File: rtl/strcmp_result_stage.sv
module strcmp_result_stage
  import strcmp_pkg::*;
#(
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  match_vec,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  input  logic [7:0]        ctrl,
  input  logic              sel_index,
  output logic              out_valid,
  output logic [OUT_W-1:0]  mask_out,
  output logic [IDX_W-1:0]  index_out,
  output logic [FLAG_W-1:0] flags_out
);
  logic             word_mode;
  logic             variant;
  logic [IDX_W-1:0] elem_cnt;
  logic [VEC_W-1:0] eff_vec;
  logic [OUT_W-1:0] mask_raw;
  logic [IDX_W-1:0] index_raw;
  logic [FLAG_W-1:0] flags_nx;
  logic [OUT_W-1:0] mask_nx;
  logic [IDX_W-1:0] index_nx;
  logic             unused_ctrl;

  assign word_mode   = ctrl[C_WIDTH];
  assign variant     = ctrl[C_VARIANT];
  assign unused_ctrl = ^{ctrl[7], ctrl[5:1]};
  assign elem_cnt    = word_mode ? IDX_W'(WORD_N) : IDX_W'(VEC_W);
  assign eff_vec     = word_mode ? {{(VEC_W-WORD_N){1'b0}}, match_vec[WORD_N-1:0]} : match_vec;

  strcmp_mask_expand u_mask (
    .eff_vec(eff_vec), .word_mode(word_mode), .expand(variant), .mask(mask_raw));
  strcmp_index_find u_index (
    .eff_vec(eff_vec), .elem_cnt(elem_cnt), .from_top(variant), .index(index_raw));
  strcmp_flag_gen u_flags (
    .eff_vec(eff_vec), .len_a(len_a), .len_b(len_b), .elem_cnt(elem_cnt), .flags(flags_nx));

  always_comb begin
    mask_nx  = sel_index ? '0 : mask_raw;
    index_nx = sel_index ? index_raw : '0;
  end

  logic             sel_q;
  logic [IDX_W-1:0] cnt_q;

  if (PIPE_EN) begin : g_pipe
    logic             valid_q;
    logic [OUT_W-1:0] mask_q;
    logic [IDX_W-1:0] index_q;
    logic [FLAG_W-1:0] flags_q;
    logic             sel_r;
    logic [IDX_W-1:0] cnt_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        mask_q  <= '0;
        index_q <= '0;
        flags_q <= '0;
        sel_r   <= 1'b0;
        cnt_r   <= '0;
      end else begin
        valid_q <= in_valid;
        if (in_valid) begin
          mask_q  <= mask_nx;
          index_q <= index_nx;
          flags_q <= flags_nx;
          sel_r   <= sel_index;
          cnt_r   <= elem_cnt;
        end
      end
    end

    assign out_valid = valid_q;
    assign mask_out  = mask_q;
    assign index_out = index_q;
    assign flags_out = flags_q;
    assign sel_q     = sel_r;
    assign cnt_q     = cnt_r;

    assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(mask_out) && $stable(index_out) && $stable(flags_out));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign mask_out  = mask_nx;
    assign index_out = index_nx;
    assign flags_out = flags_nx;
    assign sel_q     = sel_index;
    assign cnt_q     = elem_cnt;
  end

  assert_notfound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_q && !flags_out[F_CARRY]) |-> (index_out == cnt_q));
  assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel_q && flags_out[F_CARRY]) |-> (index_out < cnt_q));
  assert_ovf_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[F_OVF] |-> flags_out[F_CARRY]);
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sel_q ? (mask_out == '0) : (index_out == '0)));
endmodule

// File: tb/strcmp_result_stage_tb.sv
module strcmp_result_stage_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [15:0]  match_vec;
  logic [4:0]   len_a, len_b;
  logic [7:0]   ctrl;
  logic         sel_index;
  logic         out_valid;
  logic [127:0] mask_out;
  logic [4:0]   index_out;
  logic [5:0]   flags_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  strcmp_result_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .match_vec(match_vec),
    .len_a(len_a), .len_b(len_b), .ctrl(ctrl), .sel_index(sel_index),
    .out_valid(out_valid), .mask_out(mask_out), .index_out(index_out),
    .flags_out(flags_out));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected results computed from the requirement text
  task automatic predict(input logic [15:0] v, input logic [4:0] la, input logic [4:0] lb,
                         input logic [7:0] c, input logic m,
                         output logic [127:0] em, output logic [4:0] ei, output logic [5:0] ef);
    int cnt;
    logic [15:0] ev;
    int pos;
    cnt = c[0] ? 8 : 16;
    ev  = c[0] ? (v & 16'h00ff) : v;          // R10
    em = '0; ei = '0;
    if (m) begin
      pos = cnt;                              // R6
      if (c[6]) begin
        for (int i = cnt-1; i >= 0; i--) if (ev[i] && pos == cnt) pos = i;   // R4
      end else begin
        for (int i = 0; i < cnt; i++) if (ev[i] && pos == cnt) pos = i;      // R5
      end
      ei = 5'(pos);
    end else if (c[6]) begin
      for (int i = 0; i < cnt; i++)           // R2
        if (c[0]) em[i*16 +: 16] = ev[i] ? 16'hffff : 16'h0;
        else      em[i*8 +: 8]   = ev[i] ? 8'hff : 8'h0;
    end else begin
      em[15:0] = ev;                          // R3
    end
    ef = {ev[0], (la < cnt), (lb < cnt), 1'b0, 1'b0, (ev != 0)};  // R7 R8 R9
  endtask

  task automatic apply(input logic [15:0] v, input logic [4:0] la, input logic [4:0] lb,
                       input logic [7:0] c, input logic m);
    logic [127:0] em; logic [4:0] ei; logic [5:0] ef;
    predict(v, la, lb, c, m, em, ei, ef);
    @(negedge clk);
    match_vec = v; len_a = la; len_b = lb; ctrl = c; sel_index = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 out_valid", {127'b0, out_valid}, 128'd1);
    if (m) begin
      check(c[6] ? "R4/R6 index top" : "R5/R6 index bottom", {123'b0, index_out}, {123'b0, ei});
      check("R11 mask zero in index mode", mask_out, 128'd0);
    end else begin
      check(c[6] ? "R2 mask expand" : "R3 zero extend", mask_out, em);
      check("R11 index zero in mask mode", {123'b0, index_out}, 128'd0);
    end
    check("R7 R8 R9 flags", {122'b0, flags_out}, {122'b0, ef});
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [127:0] hold_mask; logic [4:0] hold_idx; logic [5:0] hold_flg;
    rst_n = 1'b0; in_valid = 1'b0; match_vec = '0; len_a = '0; len_b = '0;
    ctrl = '0; sel_index = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset valid", {127'b0, out_valid}, 128'd0);
    check("R12 reset mask", mask_out, 128'd0);
    check("R12 reset index", {123'b0, index_out}, 128'd0);
    check("R12 reset flags", {122'b0, flags_out}, 128'd0);
    rst_n = 1'b1;

    lfsr = 16'hace1;
    for (int combo = 0; combo < 8; combo++) begin
      logic [7:0] c;
      logic m;
      c = {1'b0, combo[1], 5'b10100, combo[0]};  // R1: bit 0 width, bit 6 variant; others noise
      m = combo[2];
      apply(16'h0000, 5'd16, 5'd16, c, m);        // all zero
      apply(16'hffff, 5'd3, 5'd9, c, m);          // all ones
      for (int b = 0; b < 16; b++)                // single bits incl. bit 0, top, ignored high
        apply(16'(1) << b, 5'(b), 5'(16 - b), c, m);
      apply(16'hff00, 5'd8, 5'd7, c, m);          // R10 only ignored bits in word mode
      for (int k = 0; k < 40; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        apply(lfsr, 5'(k % 17), 5'((k * 7) % 17), c, m);
      end
    end

    for (int a = 0; a <= 16; a++)                 // R8 length sweep
      for (int b = 0; b <= 16; b++)
        apply(16'h0101, 5'(a), 5'(b), {7'b0, 1'((a + b) & 1)}, 1'b1);

    // R12 hold while in_valid low
    apply(16'h0024, 5'd2, 5'd4, 8'h40, 1'b1);
    hold_mask = mask_out; hold_idx = index_out; hold_flg = flags_out;
    match_vec = 16'hffff; ctrl = 8'h01; sel_index = 1'b0; len_a = 5'd0;
    repeat (3) @(negedge clk);
    check("R12 idle valid low", {127'b0, out_valid}, 128'd0);
    check("R12 hold index", {123'b0, index_out}, {123'b0, hold_idx});
    check("R12 hold mask", mask_out, hold_mask);
    check("R12 hold flags", {122'b0, flags_out}, {122'b0, hold_flg});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule